// File: doc/BRIEF.md
# Four-Bank GPIO Register Block

This block is the register-mapped control point for 128 general purpose pins, split into four banks of 32. Software reaches it through a single 32-bit register port with a combinational read path. For every bank it holds an output level register, a direction register and an input inversion mask. The outputs of these registers drive the pad-side output and output-enable lines. Input pins are resynchronised through two flops, pass through the inversion mask, and are read back as one level word per bank.

Output bits can be changed without a read-modify-write cycle. Each bank has a write-only mask register that raises the selected output bits and another that lowers them. Bits written as zero are left alone. Both of these registers read as zero.

The address space has two strides. The per-bank primary registers repeat every 0x20 bytes. The set, clear and inversion registers repeat every 0x10 bytes from 0x80. In each primary window, four word slots belong to a separate interrupt block. This block only decodes those slots: it raises a select strobe with the bank and slot number, and returns that block's read data. One global mux-control word at 0x1C is stored here and driven out for the surrounding logic.

Top module: `gpio_quad_bank`

## Requirements
- R1: After reset, every output level, direction, inversion and mux-control bit is 0. Both `pin_out` and `pin_oe` are all zero.
- R2: The output level register of bank n sits at byte address n*0x20 + 0x00 and reads back what was written. It drives `pin_out[32n+31:32n]` from the clock edge that takes the write. Writes to one bank leave the other banks unchanged.
- R3: The direction register of bank n sits at n*0x20 + 0x04 and reads back what was written. A 1 bit enables the output driver of that pin through `pin_oe`, and a 0 bit leaves the pin as an input.
- R4: The level register of bank n sits at n*0x20 + 0x08 and is read-only. It returns the pin levels XORed with the bank's inversion mask. A pin change driven between two rising edges appears in the read after the second of the following rising edges, and not after the first. A write to this address changes no output, direction or inversion bit.
- R5: The raise register of bank n sits at 0x80 + n*0x10 + 0x04. Each 1 bit written sets the matching output level bit, and each 0 bit leaves it unchanged. Reads of this address return 0.
- R6: The lower register of bank n sits at 0x80 + n*0x10 + 0x00. Each 1 bit written clears the matching output level bit, and each 0 bit leaves it unchanged. Reads of this address return 0.
- R7: The inversion register of bank n sits at 0x80 + n*0x10 + 0x08 and reads back what was written. A 1 bit inverts the matching bit of the level read.
- R8: The mux-control word at 0x1C reads back what was written and drives `mux_ctrl`.
- R9: An access to n*0x20 + 0x0C, 0x10, 0x14 or 0x18 raises `irq_sel`, sets `irq_bank` to n and sets `irq_reg` to 0, 1, 2 or 3 respectively. A read at such an address returns `irq_rdata`. A write at such an address changes no register of this block.
- R10: The reserved addresses 0x3C, 0x5C, 0x7C, 0x8C, 0x9C, 0xAC, 0xBC and 0xC0 to 0xFC read as 0. Writes to them change no output, direction or mux-control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 8 | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| pin_in | input | 128 | Pin levels from the pads |
| pin_out | output | 128 | Output levels to the pads |
| pin_oe | output | 128 | Output enables to the pads (1 = drive) |
| mux_ctrl | output | 32 | Global mux-control word |
| irq_sel | output | 1 | Access falls in an interrupt block slot |
| irq_bank | output | 2 | Bank of that slot |
| irq_reg | output | 2 | Slot index 0 to 3 within the bank |
| irq_rdata | input | 32 | Read data returned by the interrupt block |

## Verification
Two events can fall in the same cycle: a pin change leaving the second synchroniser flop, and a write to the same bank's inversion mask. Both update on one edge and meet in the level read. The bench provokes this by driving a new pin pattern one cycle before the inversion write, so that both land on the same rising edge. It then judges the next level read against the new pin pattern XOR the new mask; a mixture of old and new values does not match. A second bench case checks the two-edge resynchronisation latency by reading the level register after each of the two edges.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;

  localparam int GQ_BANKS  = 4;
  localparam int GQ_BANK_W = 32;
  localparam int GQ_ADDR_W = 8;

  typedef enum logic [3:0] {
    RK_NONE, RK_DATA, RK_DIR, RK_LEVEL, RK_IRQ, RK_MUX, RK_CLR, RK_SET, RK_POL
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] bank;
    logic [1:0] sub;
  } reg_dec_t;

  // Primary window: nb banks of 0x20 bytes; mask window follows with 0x10 stride.
  function automatic reg_dec_t decode_addr(input logic [15:0] addr, input int nb);
    reg_dec_t d;
    int a, rel, slot;
    a      = int'(addr);
    d.kind = RK_NONE;
    d.bank = '0;
    d.sub  = '0;
    if (a < nb * 32) begin
      d.bank = 4'(a / 32);
      slot   = (a % 32) / 4;
      case (slot)
        0: d.kind = RK_DATA;
        1: d.kind = RK_DIR;
        2: d.kind = RK_LEVEL;
        3, 4, 5, 6: begin
          d.kind = RK_IRQ;
          d.sub  = 2'(slot - 3);
        end
        7: if (a / 32 == 0) d.kind = RK_MUX;
        default: d.kind = RK_NONE;
      endcase
    end else if (a < nb * 48) begin
      rel    = a - nb * 32;
      d.bank = 4'(rel / 16);
      slot   = (rel % 16) / 4;
      case (slot)
        0: d.kind = RK_CLR;
        1: d.kind = RK_SET;
        2: d.kind = RK_POL;
        default: d.kind = RK_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_quad_sync.sv
module gpio_quad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/gpio_quad_slice.sv
module gpio_quad_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_data,
  input  logic         ld_dir,
  input  logic         ld_pol,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dout,
  output logic [W-1:0] dir,
  output logic [W-1:0] pol
);
  // Full load replaces; otherwise the raise mask is applied after the lower mask.
  function automatic logic [W-1:0] next_level(input logic [W-1:0] cur,
                                              input logic         load,
                                              input logic [W-1:0] ld_val,
                                              input logic [W-1:0] set_m,
                                              input logic [W-1:0] clr_m);
    if (load) return ld_val;
    return (cur & ~clr_m) | set_m;
  endfunction

  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  assign set_mask = set_en ? wdata : '0;
  assign clr_mask = clr_en ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
      pol  <= '0;
    end else begin
      dout <= next_level(dout, ld_data, wdata, set_mask, clr_mask);
      if (ld_dir) dir <= wdata;
      if (ld_pol) pol <= wdata;
    end
  end
endmodule

// File: rtl/gpio_quad_bank.sv
module gpio_quad_bank
  import gpio_quad_pkg::*;
#(
  parameter int NB = GQ_BANKS,
  parameter int BW = GQ_BANK_W,
  parameter int AW = GQ_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_en,
  input  logic                   reg_we,
  input  logic [AW-1:0]          reg_addr,
  input  logic [BW-1:0]          reg_wdata,
  output logic [BW-1:0]          reg_rdata,
  input  logic [NB*BW-1:0]       pin_in,
  output logic [NB*BW-1:0]       pin_out,
  output logic [NB*BW-1:0]       pin_oe,
  output logic [BW-1:0]          mux_ctrl,
  output logic                   irq_sel,
  output logic [((NB > 1) ? $clog2(NB) : 1)-1:0] irq_bank,
  output logic [1:0]             irq_reg,
  input  logic [BW-1:0]          irq_rdata
);
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1;
  localparam int PW  = NB * BW;

  reg_dec_t       dec;
  logic           acc_wr;
  logic [BIW-1:0] bsel;
  logic [BW-1:0]  mux_q;
  logic [PW-1:0]  level_q;

  // Named internal events
  logic [NB-1:0]  ev_ld_data, ev_ld_dir, ev_ld_pol, ev_set, ev_clr;
  logic           ev_mux_wr;

  logic [BW-1:0]  dout_a  [NB];
  logic [BW-1:0]  dir_a   [NB];
  logic [BW-1:0]  pol_a   [NB];
  logic [BW-1:0]  level_a [NB];

  assign dec       = decode_addr(16'(reg_addr), NB);
  assign acc_wr    = reg_en & reg_we;
  assign bsel      = BIW'(dec.bank);
  assign ev_mux_wr = acc_wr && (dec.kind == RK_MUX);

  gpio_quad_sync #(.W(PW)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (level_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit           = acc_wr && (dec.bank == 4'(b));
    assign ev_ld_data[b] = hit && (dec.kind == RK_DATA);
    assign ev_ld_dir[b]  = hit && (dec.kind == RK_DIR);
    assign ev_ld_pol[b]  = hit && (dec.kind == RK_POL);
    assign ev_set[b]     = hit && (dec.kind == RK_SET);
    assign ev_clr[b]     = hit && (dec.kind == RK_CLR);

    gpio_quad_slice #(.W(BW)) slice_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_data (ev_ld_data[b]),
      .ld_dir  (ev_ld_dir[b]),
      .ld_pol  (ev_ld_pol[b]),
      .set_en  (ev_set[b]),
      .clr_en  (ev_clr[b]),
      .wdata   (reg_wdata),
      .dout    (dout_a[b]),
      .dir     (dir_a[b]),
      .pol     (pol_a[b])
    );

    assign level_a[b]          = level_q[b*BW +: BW] ^ pol_a[b];
    assign pin_out[b*BW +: BW] = dout_a[b];
    assign pin_oe[b*BW +: BW]  = dir_a[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mux_q <= '0;
    else if (ev_mux_wr) mux_q <= reg_wdata;
  end
  assign mux_ctrl = mux_q;

  always_comb begin
    case (dec.kind)
      RK_DATA:  reg_rdata = dout_a[bsel];
      RK_DIR:   reg_rdata = dir_a[bsel];
      RK_LEVEL: reg_rdata = level_a[bsel];
      RK_POL:   reg_rdata = pol_a[bsel];
      RK_IRQ:   reg_rdata = irq_rdata;
      RK_MUX:   reg_rdata = mux_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_sel  = reg_en && (dec.kind == RK_IRQ);
  assign irq_bank = bsel;
  assign irq_reg  = dec.sub;
endmodule

// File: rtl/gpio_quad_bank_chk.sv
module gpio_quad_bank_chk #(
  parameter int NB  = 4,
  parameter int BW  = 32,
  parameter int AW  = 8,
  parameter int BIW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_en,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [BW-1:0]    reg_wdata,
  input logic [BW-1:0]    reg_rdata,
  input logic [NB*BW-1:0] pin_out,
  input logic [NB*BW-1:0] pin_oe,
  input logic [BW-1:0]    mux_ctrl,
  input logic             irq_sel,
  input logic [BIW-1:0]   irq_bank,
  input logic [BW-1:0]    irq_rdata
);
  int  a_int;
  logic wo_read, resv_wr, wr;
  assign a_int   = int'(reg_addr);
  assign wr      = reg_en && reg_we;
  assign wo_read = reg_en && !reg_we && (a_int >= NB*32) && (a_int < NB*48)
                   && (((a_int - NB*32) % 16) < 8);
  assign resv_wr = wr && (a_int >= NB*48);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && mux_ctrl == '0));

  p_wo_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wo_read |-> reg_rdata == '0);

  p_irq_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel && !reg_we) |-> reg_rdata == irq_rdata);

  p_resv_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resv_wr |=> ($stable(pin_out) && $stable(pin_oe) && $stable(mux_ctrl)));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(b*32)) |=> pin_out[b*BW +: BW] == $past(reg_wdata));

    p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(b*32 + 4)) |=> pin_oe[b*BW +: BW] == $past(reg_wdata));

    p_level_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(b*32 + 8)) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(NB*32 + b*16 + 4))
      |=> (pin_out[b*BW +: BW] & $past(reg_wdata)) == $past(reg_wdata));

    p_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == AW'(NB*32 + b*16))
      |=> (pin_out[b*BW +: BW] & $past(reg_wdata)) == '0);

    p_irq_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && reg_addr == AW'(b*32 + 12)) |-> (irq_sel && irq_bank == BIW'(b)));
  end
endmodule

bind gpio_quad_bank gpio_quad_bank_chk #(.NB(NB), .BW(BW), .AW(AW), .BIW(BIW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .mux_ctrl  (mux_ctrl),
  .irq_sel   (irq_sel),
  .irq_bank  (irq_bank),
  .irq_rdata (irq_rdata)
);

// File: tb/gpio_quad_bank_tb_top.sv
module gpio_quad_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic [31:0]  mux_ctrl;
  logic         irq_sel;
  logic [1:0]   irq_bank, irq_reg;
  logic [31:0]  irq_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_quad_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .mux_ctrl(mux_ctrl),
    .irq_sel(irq_sel), .irq_bank(irq_bank), .irq_reg(irq_reg), .irq_rdata(irq_rdata)
  );

  function automatic logic [7:0] pa(input int b, input int o);
    return 8'(b * 32 + o);
  endfunction
  function automatic logic [7:0] sa(input int b, input int o);
    return 8'(128 + b * 16 + o);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "pin_out", pin_out, '0);
    chk("R1", "pin_oe", pin_oe, '0);
    chk("R1", "mux_ctrl", {96'h0, mux_ctrl}, '0);
    for (int b = 0; b < 4; b++) begin
      rd(sa(b, 8), v);
      chk("R1", "inversion", {96'h0, v}, '0);
    end
  endtask

  task automatic t_data();
    logic [31:0] v;
    logic [127:0] exp;
    exp = '0;
    for (int b = 0; b < 4; b++) begin
      wr(pa(b, 0), 32'h1111_0000 * (b + 1) + 32'h0000_00A5);
      exp[b*32 +: 32] = 32'h1111_0000 * (b + 1) + 32'h0000_00A5;
      chk("R2", "pin_out after bank write", pin_out, exp);
    end
    for (int b = 0; b < 4; b++) begin
      rd(pa(b, 0), v);
      chk("R2", "data readback", {96'h0, v}, {96'h0, exp[b*32 +: 32]});
    end
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(pa(2, 4), 32'hDEAD_BEEF);
    chk("R3", "pin_oe bank2", pin_oe, {32'h0, 32'hDEAD_BEEF, 64'h0});
    rd(pa(2, 4), v);
    chk("R3", "dir readback", {96'h0, v}, {96'h0, 32'hDEAD_BEEF});
  endtask

  task automatic t_raise_lower();
    logic [31:0] v;
    wr(pa(1, 0), 32'hF0F0_F0F0);
    wr(sa(1, 4), 32'h0000_000F);
    chk("R5", "raise result", {96'h0, pin_out[63:32]}, {96'h0, 32'hF0F0_F0FF});
    wr(sa(1, 0), 32'hF000_0001);
    chk("R6", "lower result", {96'h0, pin_out[63:32]}, {96'h0, 32'h00F0_F0FE});
    chk("R6", "other banks kept", {pin_out[127:64], pin_out[31:0]},
        {32'h4444_00A5, 32'h3333_00A5, 32'h1111_00A5});
    rd(sa(1, 4), v);
    chk("R5", "raise reads zero", {96'h0, v}, '0);
    rd(sa(1, 0), v);
    chk("R6", "lower reads zero", {96'h0, v}, '0);
  endtask

  task automatic t_level_sync();
    logic [31:0] v;
    @(negedge clk);
    pin_in[31:0] = 32'hCAFE_0123;
    rd(pa(0, 8), v);
    chk("R4", "level after one edge", {96'h0, v}, '0);
    rd(pa(0, 8), v);
    chk("R4", "level after two edges", {96'h0, v}, {96'h0, 32'hCAFE_0123});
    wr(pa(0, 8), 32'hFFFF_FFFF);
    chk("R4", "level write ignored (out)", pin_out[31:0], 128'h1111_00A5);
    chk("R4", "level write ignored (oe)", pin_oe[31:0], '0);
  endtask

  task automatic t_inversion_coincident();
    logic [31:0] v;
    wr(sa(2, 8), 32'hFFFF_0000);
    pin_in[95:64] = 32'h1234_5678;
    rd(pa(2, 8), v);
    rd(pa(2, 8), v);
    chk("R7", "inverted level", {96'h0, v}, {96'h0, 32'h1234_5678 ^ 32'hFFFF_0000});
    // New pins and new mask reach the read on the same edge.
    @(negedge clk);
    pin_in[95:64] = 32'h0F0F_AAAA;
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = sa(2, 8); reg_wdata = 32'h00FF_00FF;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = pa(2, 8);
    #1 v = reg_rdata;
    reg_en = 1'b0;
    chk("R7", "coincident pin+mask", {96'h0, v}, {96'h0, 32'h0F0F_AAAA ^ 32'h00FF_00FF});
  endtask

  task automatic t_mux();
    logic [31:0] v;
    wr(8'h1C, 32'h8000_0013);
    chk("R8", "mux_ctrl", {96'h0, mux_ctrl}, {96'h0, 32'h8000_0013});
    rd(8'h1C, v);
    chk("R8", "mux readback", {96'h0, v}, {96'h0, 32'h8000_0013});
  endtask

  task automatic t_irq();
    logic [127:0] po;
    irq_rdata = 32'hA5A5_1234;
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = pa(1, 12);
    #1;
    chk("R9", "sel/bank/slot @0x2C", {124'h0, irq_sel, irq_bank, irq_reg[0]}, {124'h0, 1'b1, 2'd1, 1'b0});
    chk("R9", "passthrough read", {96'h0, reg_rdata}, {96'h0, 32'hA5A5_1234});
    reg_addr = pa(3, 24);
    #0.5;
    chk("R9", "bank3 slot3", {124'h0, irq_sel, irq_bank, irq_reg[1]}, {124'h0, 1'b1, 2'd3, 1'b1});
    chk("R9", "slot index", {126'h0, irq_reg}, {126'h0, 2'd3});
    reg_en = 1'b0;
    po = pin_out;
    wr(pa(0, 16), 32'hFFFF_FFFF);
    chk("R9", "irq write no effect", pin_out, po);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    logic [127:0] po, oe;
    logic [31:0] mx;
    po = pin_out; oe = pin_oe; mx = mux_ctrl;
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    chk("R10", "outputs kept", pin_out, po);
    chk("R10", "enables kept", pin_oe, oe);
    chk("R10", "mux kept", {96'h0, mux_ctrl}, {96'h0, mx});
    rd(8'h5C, v);
    chk("R10", "0x5C reads zero", {96'h0, v}, '0);
    rd(8'hFC, v);
    chk("R10", "0xFC reads zero", {96'h0, v}, '0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_dir();
    t_raise_lower();
    t_level_sync();
    t_inversion_coincident();
    t_mux();
    t_irq();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule